// File: doc/BRIEF.md
# Interrupt Status and Vector Unit

This unit gathers the event pulses of a serial bus controller into a 16-bit sticky status word. It qualifies that word with an enable mask to drive a single interrupt line. Software sees the status word through a readback port, where the live bus-busy level appears in bit 12. Software acknowledges sources in one of two ways. It can write ones to the status word, and only a fixed set of bits accepts this. It can also pulse the vector read strobe: the vector port shows the one-based number of the lowest pending enabled source, and the strobe clears that one source.

Two DMA request lines follow the receive-ready flag (bit 3) and the transmit-ready flag (bit 4). Each line is gated by its own enable bit in a small DMA configuration register. Turning a DMA direction on also masks the matching ready interrupt, so the same event never both interrupts the processor and requests a transfer. The configuration register is written through the same register port as the status word and the enable mask.

Top module: `irq_vec_unit`

## Requirements
- R1: After a synchronous reset the status word, enable mask and DMA configuration read zero, and `irq_o`, both DMA requests and `vec_o` are low.
- R2: A one on any bit of `evt_i` other than bit 12 sets that status bit at the next clock edge. The bit then stays set until it is cleared. Bit 12 is never stored.
- R3: A register write with `wr_sel_i` = 0 clears only those status bits that are one in both the data and 0x63E7. Bits 3, 4, 10, 11 and 15 cannot be cleared this way.
- R4: A register write with `wr_sel_i` = 1 loads the enable mask with the data ANDed with 0x63FF.
- R5: `irq_o` is high exactly when the stored status AND the enable mask is nonzero.
- R6: `vec_o` gives the one-based position of the lowest bit set in status AND enable, and gives 0 when no such bit is set.
- R7: When `vec_rd_i` is high, the bit named by `vec_o` is cleared at that clock edge and no other bit changes.
- R8: When an event sets a status bit in the same cycle that a software write or a vector read clears it, the bit ends up set.
- R9: Bit 12 of `stat_o` follows `bus_busy_i` combinationally in the same cycle.
- R10: `rx_dreq_o` equals DMA configuration bit 15 AND status bit 3, and `tx_dreq_o` equals configuration bit 7 AND status bit 4. Both lines are registered, so each follows its operands one clock later.
- R11: A register write with `wr_sel_i` = 2 clears enable bit 3 when data bit 15 is one, and clears enable bit 4 when data bit 7 is one.
- R12: The DMA configuration register keeps only data bits 15 and 7 (mask 0x8080).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 16 | Event pulses, one per status bit |
| bus_busy_i | input | 1 | Live bus-busy level |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 status, 1 enable mask, 2 DMA configuration, 3 none |
| wr_data_i | input | 16 | Write data |
| vec_rd_i | input | 1 | Vector read strobe (acknowledges the shown source) |
| stat_o | output | 16 | Status readback, with bus-busy in bit 12 |
| ena_o | output | 16 | Enable mask readback |
| dma_o | output | 16 | DMA configuration readback |
| vec_o | output | 5 | One-based number of the lowest pending enabled source, 0 if none |
| irq_o | output | 1 | Interrupt line |
| rx_dreq_o | output | 1 | Receive DMA request |
| tx_dreq_o | output | 1 | Transmit DMA request |

## Verification
A directed phase drives all events at once, first with the bus busy and then idle. This separates the stored bits from the live busy bit, and it shows which bits survive a write of all ones to the status word. The next steps walk the vector through consecutive acknowledges down to zero. Same-cycle collisions of a set with a write-clear, and of a set with a vector read, show whether the set takes priority. A random phase then mixes sparse events, writes to every target and vector reads, and compares each cycle against a behavioural model. This exposes priority order, masking and the one-cycle lag of the DMA requests.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

    localparam int unsigned REG_W      = 16;
    localparam int unsigned VEC_W      = $clog2(REG_W + 1);

    localparam int unsigned BUSY_BIT   = 12;
    localparam int unsigned RX_RDY_BIT = 3;
    localparam int unsigned TX_RDY_BIT = 4;
    localparam int unsigned RX_DMA_BIT = 15;
    localparam int unsigned TX_DMA_BIT = 7;

    localparam logic [REG_W-1:0] SW_CLR_MASK = 16'h63E7;
    localparam logic [REG_W-1:0] ENA_MASK    = 16'h63FF;
    localparam logic [REG_W-1:0] DMA_MASK    =
        (REG_W'(1) << RX_DMA_BIT) | (REG_W'(1) << TX_DMA_BIT);
    localparam logic [REG_W-1:0] STORE_MASK  = ~(REG_W'(1) << BUSY_BIT);

    typedef enum logic [1:0] {
        SEL_STAT = 2'd0,
        SEL_ENA  = 2'd1,
        SEL_DMA  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [REG_W-1:0] set;
        logic [REG_W-1:0] clr;
    } stat_upd_t;

    function automatic logic [REG_W-1:0] sw_clear(input logic hit,
                                                  input logic [REG_W-1:0] data);
        return hit ? (data & SW_CLR_MASK) : '0;
    endfunction

endpackage

// File: rtl/irq_vec_status.sv
module irq_vec_status
    import irq_vec_pkg::*;
#(
    parameter int unsigned W = REG_W
) (
    input  logic         clk,
    input  logic         rst,
    input  stat_upd_t    upd_i,
    output logic [W-1:0] stat_o
);
    logic [W-1:0] stat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else begin
            // a set outranks any clear aimed at the same bit
            stat_q <= ((stat_q & ~upd_i.clr) | upd_i.set) & STORE_MASK;
        end
    end

    assign stat_o = stat_q;

    AST_SET_STICKS: assert property (@(posedge clk) disable iff (rst)
        (|(upd_i.set & STORE_MASK)) |=>
            ((stat_q & $past(upd_i.set) & STORE_MASK) == ($past(upd_i.set) & STORE_MASK))) // R8
        else $error("set event lost");

    AST_BUSY_NOT_HELD: assert property (@(posedge clk) disable iff (rst)
        !stat_q[BUSY_BIT]) // R2
        else $error("busy bit stored");

endmodule

// File: rtl/irq_vec_prio.sv
module irq_vec_prio
    import irq_vec_pkg::*;
#(
    parameter int unsigned W  = REG_W,
    parameter int unsigned VW = VEC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  pend_i,
    output logic [W-1:0]  grant_o,
    output logic [VW-1:0] vec_o
);
    logic [W:0] below;
    assign below[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_chain
        assign below[i+1]  = below[i] | pend_i[i];
        assign grant_o[i]  = pend_i[i] & ~below[i];
    end

    always_comb begin
        vec_o = '0;
        for (int i = 0; i < W; i++) begin
            if (grant_o[i]) vec_o = vec_o | VW'(i + 1);
        end
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_o)) // R6
        else $error("more than one grant");

    AST_GRANT_IFF_PEND: assert property (@(posedge clk) disable iff (rst)
        (|pend_i) == (vec_o != '0)) // R6
        else $error("vector and pending disagree");

endmodule

// File: rtl/irq_vec_dma.sv
module irq_vec_dma
    import irq_vec_pkg::*;
#(
    parameter int unsigned W = REG_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_i,
    input  logic [W-1:0] data_i,
    input  logic         rx_rdy_i,
    input  logic         tx_rdy_i,
    output logic [W-1:0] cfg_o,
    output logic [W-1:0] ena_knock_o,
    output logic         rx_dreq_o,
    output logic         tx_dreq_o
);
    logic [W-1:0] cfg_q;
    logic         rx_q, tx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            rx_q  <= 1'b0;
            tx_q  <= 1'b0;
        end else begin
            if (wr_i) cfg_q <= data_i & DMA_MASK;
            rx_q <= cfg_q[RX_DMA_BIT] & rx_rdy_i;
            tx_q <= cfg_q[TX_DMA_BIT] & tx_rdy_i;
        end
    end

    always_comb begin
        ena_knock_o = '0;
        if (wr_i) begin
            ena_knock_o[RX_RDY_BIT] = data_i[RX_DMA_BIT];
            ena_knock_o[TX_RDY_BIT] = data_i[TX_DMA_BIT];
        end
    end

    assign cfg_o     = cfg_q;
    assign rx_dreq_o = rx_q;
    assign tx_dreq_o = tx_q;

    AST_RX_DREQ_LAG: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_dreq_o) |-> $past(rx_rdy_i)) // R10
        else $error("rx request without ready");

    AST_TX_DREQ_LAG: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_dreq_o) |-> $past(tx_rdy_i)) // R10
        else $error("tx request without ready");

endmodule

// File: rtl/irq_vec_unit.sv
module irq_vec_unit
    import irq_vec_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] evt_i,
    input  logic             bus_busy_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_sel_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic             vec_rd_i,
    output logic [REG_W-1:0] stat_o,
    output logic [REG_W-1:0] ena_o,
    output logic [REG_W-1:0] dma_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             irq_o,
    output logic             rx_dreq_o,
    output logic             tx_dreq_o
);
    reg_sel_e         sel;
    logic             wr_stat, wr_ena, wr_dma;
    logic [REG_W-1:0] stat_q, ena_q, pend, grant, knock;
    stat_upd_t        upd;

    assign sel     = reg_sel_e'(wr_sel_i);
    assign wr_stat = wr_en_i && (sel == SEL_STAT);
    assign wr_ena  = wr_en_i && (sel == SEL_ENA);
    assign wr_dma  = wr_en_i && (sel == SEL_DMA);

    assign pend = stat_q & ena_q;

    always_comb begin
        upd.set = evt_i;
        upd.clr = sw_clear(wr_stat, wr_data_i);
        if (vec_rd_i) upd.clr = upd.clr | grant;
    end

    irq_vec_status #(.W(REG_W)) u_status (
        .clk    (clk),
        .rst    (rst),
        .upd_i  (upd),
        .stat_o (stat_q)
    );

    irq_vec_prio #(.W(REG_W), .VW(VEC_W)) u_prio (
        .clk     (clk),
        .rst     (rst),
        .pend_i  (pend),
        .grant_o (grant),
        .vec_o   (vec_o)
    );

    irq_vec_dma #(.W(REG_W)) u_dma (
        .clk         (clk),
        .rst         (rst),
        .wr_i        (wr_dma),
        .data_i      (wr_data_i),
        .rx_rdy_i    (stat_q[RX_RDY_BIT]),
        .tx_rdy_i    (stat_q[TX_RDY_BIT]),
        .cfg_o       (dma_o),
        .ena_knock_o (knock),
        .rx_dreq_o   (rx_dreq_o),
        .tx_dreq_o   (tx_dreq_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ena_q <= '0;
        end else if (wr_ena) begin
            ena_q <= wr_data_i & ENA_MASK;
        end else begin
            ena_q <= ena_q & ~knock;
        end
    end

    assign ena_o  = ena_q;
    assign irq_o  = |pend;
    assign stat_o = stat_q | (REG_W'(bus_busy_i) << BUSY_BIT);

    AST_IRQ_HAS_VEC: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (vec_o != '0)) // R5
        else $error("irq without vector");

    AST_SW_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && !vec_rd_i) |=>
            ((stat_q & $past(stat_q) & ~SW_CLR_MASK) == ($past(stat_q) & ~SW_CLR_MASK))) // R3
        else $error("locked bit cleared by software");

    AST_VEC_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (vec_rd_i && (|grant) && !(|(grant & evt_i))) |=>
            ((stat_q & $past(grant)) == '0)) // R7
        else $error("vector read did not acknowledge");

    AST_DMA_MASKS_RX: assert property (@(posedge clk) disable iff (rst)
        (wr_dma && wr_data_i[RX_DMA_BIT]) |=> !ena_q[RX_RDY_BIT]) // R11
        else $error("rx ready still enabled");

    AST_DMA_MASKS_TX: assert property (@(posedge clk) disable iff (rst)
        (wr_dma && wr_data_i[TX_DMA_BIT]) |=> !ena_q[TX_RDY_BIT]) // R11
        else $error("tx ready still enabled");

endmodule

// File: tb/irq_vec_unit_tb.sv
`timescale 1ns/1ps
module irq_vec_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] evt = '0;
    logic        busy = 1'b0;
    logic        wr = 1'b0;
    logic [1:0]  sel = 2'd3;
    logic [15:0] wd = '0;
    logic        vrd = 1'b0;
    logic [15:0] stat_o, ena_o, dma_o;
    logic [4:0]  vec_o;
    logic        irq_o, rxd_o, txd_o;

    int tests = 0;
    int fails = 0;

    // reference model state
    logic [15:0] m_stat = '0, m_ena = '0, m_dma = '0;
    logic        m_rx = 1'b0, m_tx = 1'b0;

    always #2 clk = ~clk;

    irq_vec_unit u_dut (
        .clk(clk), .rst(rst), .evt_i(evt), .bus_busy_i(busy),
        .wr_en_i(wr), .wr_sel_i(sel), .wr_data_i(wd), .vec_rd_i(vrd),
        .stat_o(stat_o), .ena_o(ena_o), .dma_o(dma_o), .vec_o(vec_o),
        .irq_o(irq_o), .rx_dreq_o(rxd_o), .tx_dreq_o(txd_o)
    );

    function automatic int low_num(input logic [15:0] v);
        for (int i = 0; i < 16; i++) if (v[i]) return i + 1;
        return 0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // behavioural model, advanced on each rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_stat = '0; m_ena = '0; m_dma = '0; m_rx = 1'b0; m_tx = 1'b0;
        end else begin
            automatic logic [15:0] clr = '0;
            automatic int n = low_num(m_stat & m_ena);
            automatic logic nrx = m_dma[15] & m_stat[3];
            automatic logic ntx = m_dma[7] & m_stat[4];
            if (wr && sel == 2'd0) clr = wd & 16'h63E7;
            if (vrd && n != 0) clr[n-1] = 1'b1;
            m_stat = ((m_stat & ~clr) | evt) & 16'hEFFF;
            if (wr && sel == 2'd1) m_ena = wd & 16'h63FF;
            if (wr && sel == 2'd2) begin
                m_dma = wd & 16'h8080;
                if (wd[15]) m_ena[3] = 1'b0;
                if (wd[7])  m_ena[4] = 1'b0;
            end
            m_rx = nrx; m_tx = ntx;
        end
    end

    // cycle-by-cycle comparison away from the edge
    always @(negedge clk) begin
        #0.5;
        if (!rst) begin
            chk("R2 status", stat_o, m_stat | (16'(busy) << 12));
            chk("R4 enable", ena_o, m_ena);
            chk("R12 dma cfg", dma_o, m_dma);
            chk("R6 vector", vec_o, low_num(m_stat & m_ena));
            chk("R5 irq", irq_o, |(m_stat & m_ena));
            chk("R10 rx dreq", rxd_o, m_rx);
            chk("R10 tx dreq", txd_o, m_tx);
        end
    end

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic idle();
        evt = '0; wr = 1'b0; sel = 2'd3; wd = '0; vrd = 1'b0;
    endtask

    task automatic wreg(input logic [1:0] s, input logic [15:0] d);
        wr = 1'b1; sel = s; wd = d; cyc(); idle();
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        rst = 1'b0;
        chk("R1 stat", stat_o, 16'h0);
        chk("R1 ena", ena_o, 16'h0);
        chk("R1 dma", dma_o, 16'h0);
        chk("R1 irq/vec/dreq", {irq_o, vec_o, rxd_o, txd_o}, '0);

        evt = 16'hFFFF; busy = 1'b1; cyc(); idle();
        chk("R9 busy live high", stat_o, 16'hFFFF);
        busy = 1'b0; #0.2;
        chk("R9 busy not stored", stat_o, 16'hEFFF);

        wreg(2'd0, 16'hFFFF);
        chk("R3 locked bits survive", stat_o, 16'h8C18);

        wreg(2'd1, 16'hFFFF);
        chk("R4 enable mask", ena_o, 16'h63FF);
        chk("R5 irq high", irq_o, 1'b1);
        chk("R6 lowest is bit3", vec_o, 5'd4);

        vrd = 1'b1; cyc(); idle();
        chk("R7 ack bit3", stat_o, 16'h8C10);
        chk("R6 next is bit4", vec_o, 5'd5);
        vrd = 1'b1; cyc(); idle();
        chk("R7 ack bit4", stat_o, 16'h8C00);
        chk("R6 none pending", vec_o, 5'd0);
        chk("R5 irq low", irq_o, 1'b0);

        evt = 16'h0001; wr = 1'b1; sel = 2'd0; wd = 16'h0001; cyc(); idle();
        chk("R8 set beats write clear", stat_o, 16'h8C01);
        wreg(2'd0, 16'h0001);
        chk("R3 clearable bit0", stat_o, 16'h8C00);
        evt = 16'h0001; cyc(); idle();
        evt = 16'h0001; vrd = 1'b1; cyc(); idle();
        chk("R8 set beats vector ack", stat_o, 16'h8C01);
        vrd = 1'b1; cyc(); idle();
        chk("R7 vector ack bit0", stat_o, 16'h8C00);

        wreg(2'd2, 16'h8080);
        chk("R12 dma cfg", dma_o, 16'h8080);
        chk("R11 ready enables masked", ena_o, 16'h63E7);
        evt = 16'h0008; cyc(); idle();
        chk("R10 rx dreq lags", rxd_o, 1'b0);
        cyc();
        chk("R10 rx dreq asserted", rxd_o, 1'b1);
        chk("R10 tx dreq idle", txd_o, 1'b0);
        wreg(2'd2, 16'hFFFF);
        chk("R12 dma keeps two bits", dma_o, 16'h8080);

        for (int k = 0; k < 4000; k++) begin
            evt  = 16'($urandom) & 16'($urandom) & 16'($urandom);
            busy = 1'($urandom);
            wr   = ($urandom % 5) == 0;
            sel  = 2'($urandom);
            wd   = 16'($urandom);
            vrd  = ($urandom % 3) == 0;
            cyc();
        end
        idle();
        cyc();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule